// File: doc/BRIEF.md
# Backplane Master Cycle Sequencer

This block lets a host that has only a simple parallel port act as master on an asynchronous backplane bus. The host first writes the low address byte and a write data byte into holding registers, each with a one-clock load pulse. It then sets the transfer direction and raises a start request. A chain of clocked stages then turns on the bus drivers, asserts the address strobe, and asserts the data strobe. The chain waits for the slave acknowledge and then closes the cycle.

On a read, the data the slave places on the bus is captured into a holding register. That register keeps its value until the host collects it at any later time. On a write, the write data byte sits on the data lines for the whole cycle. Arbitration happens outside this block: it only sees a grant level. The physical drivers are also outside; the block supplies their enable. The design is meant for a 16 MHz system clock, but nothing in it depends on that frequency.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, `drv_en` is 0, `busy` is 0, both strobes (`adr_stb_n`, `dat_stb_n`) are 1, and `rd_hold`, `bus_addr` and `bus_data_out` are all 0.
- R2: A clock edge that samples `start`=1 and `grant`=1 while `busy`=0 sets `drv_en`=1 and `busy`=1 after that edge. Both strobes stay at 1 in that first clock.
- R3: `adr_stb_n` goes to 0 exactly one clock after `drv_en` rises.
- R4: `dat_stb_n` goes to 0 exactly one clock after `adr_stb_n` falls, while `adr_stb_n` stays at 0.
- R5: While the data strobe is asserted, the strobes hold until an edge samples `ack_n`=0. After that edge, both strobes return to 1 together. One clock later `drv_en` and `busy` return to 0.
- R6: `start` is ignored when `grant`=0 or when `busy`=1. An ignored start neither begins nor restarts a cycle.
- R7: A clock edge with `addr_load`=1 and `busy`=0 copies `addr_in` into the register that drives `bus_addr`. Loads while `busy`=1 are ignored.
- R8: A clock edge with `wdata_load`=1 and `busy`=0 copies `wdata_in` into the register that drives `bus_data_out`. Loads while busy are ignored. A write cycle leaves `rd_hold` unchanged.
- R9: In a read cycle (`bus_rd`=1), `rd_hold` takes `bus_data_in` on the edge that first samples `ack_n`=0 during the data strobe. It then keeps that value through later idle time and write cycles.
- R10: `dir_rd` (1 = read, 0 = write) is sampled on the edge that accepts the start. `bus_rd` shows that value unchanged for the whole cycle, even if `dir_rd` changes later.
- R11: `ack_n`=0 seen before the data strobe is asserted does not shorten the cycle. The data strobe is still low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 8 | Address byte from the host port |
| addr_load | input | 1 | Host pulse that loads the address register |
| wdata_in | input | 8 | Write data byte from the host port |
| wdata_load | input | 1 | Host pulse that loads the write data register |
| dir_rd | input | 1 | Direction for the next cycle, 1 = read |
| start | input | 1 | Request to begin a cycle |
| grant | input | 1 | Bus ownership granted by the external arbiter |
| ack_n | input | 1 | Slave acknowledge, active low |
| bus_data_in | input | 8 | Data lines as seen from the bus |
| bus_addr | output | 8 | Low address lines |
| bus_data_out | output | 8 | Write data lines |
| bus_rd | output | 1 | Direction of the running cycle, 1 = read |
| drv_en | output | 1 | Bus driver enable |
| adr_stb_n | output | 1 | Address strobe, active low |
| dat_stb_n | output | 1 | Data strobe, active low |
| busy | output | 1 | Cycle in progress |
| rd_hold | output | 8 | Read holding register |

## Verification
Call the edge that accepts a start edge k. `drv_en` is due after edge k, the address strobe after k+1, and the data strobe after k+2. Both strobes release one edge after acknowledge is sampled, and `drv_en` drops one edge after that. Register loads show at the outputs one edge after their pulse. The bench changes inputs on falling edges and checks each output at the falling edge that follows the rising edge on which that output is due. Acknowledge delays are swept from zero to three clocks, so the strobes are also checked while they must hold.

// File: rtl/bus_cycle_seq_pkg.sv
package bus_cycle_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DRIVE = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DATA  = 3'd3,
    PH_CLOSE = 3'd4
  } phase_t;
endpackage

// File: rtl/bcs_host_regs.sv
module bcs_host_regs #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [AW-1:0] addr_in,
  input  logic          addr_load,
  input  logic [DW-1:0] wdata_in,
  input  logic          wdata_load,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);
  logic          addr_en, wdata_en;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    addr_en  = addr_load  && !busy;
    wdata_en = wdata_load && !busy;
    addr_d   = addr_en  ? addr_in  : addr_q;
    wdata_d  = wdata_en ? wdata_in : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
  assert_wdata_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wdata_q));
endmodule

// File: rtl/bcs_timing_chain.sv
module bcs_timing_chain
  import bus_cycle_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic grant,
  input  logic dir_rd,
  input  logic ack_n,
  output logic drv_en,
  output logic adr_stb_n,
  output logic dat_stb_n,
  output logic busy,
  output logic cyc_rd,
  output logic capture
);
  phase_t ph_q, ph_d;
  logic   rd_d;
  logic   accept;

  always_comb begin
    accept = start && grant && (ph_q == PH_IDLE);
    ph_d   = ph_q;
    rd_d   = accept ? dir_rd : cyc_rd;
    unique case (ph_q)
      PH_IDLE:  if (accept) ph_d = PH_DRIVE;
      PH_DRIVE: ph_d = PH_ADDR;
      PH_ADDR:  ph_d = PH_DATA;
      PH_DATA:  if (!ack_n) ph_d = PH_CLOSE;
      PH_CLOSE: ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cyc_rd <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cyc_rd <= rd_d;
    end
  end

  always_comb begin
    drv_en    = (ph_q != PH_IDLE);
    busy      = (ph_q != PH_IDLE);
    adr_stb_n = !((ph_q == PH_ADDR) || (ph_q == PH_DATA));
    dat_stb_n = !(ph_q == PH_DATA);
    capture   = (ph_q == PH_DATA) && !ack_n && cyc_rd;
  end

  assert_drv_before_adr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adr_stb_n) |-> $past(drv_en) && $past(dat_stb_n));
  assert_dat_after_adr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_stb_n) |-> !adr_stb_n && $past(!adr_stb_n));
  assert_strobes_release_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adr_stb_n) |-> $rose(dat_stb_n) && drv_en);
  assert_drv_drop_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_stb_n) |=> !drv_en && !busy);
  assert_no_grant_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !busy) |=> !busy);
  assert_dir_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cyc_rd));
endmodule

// File: rtl/bcs_read_hold.sv
module bcs_read_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] bus_data_in,
  output logic [DW-1:0] hold_q
);
  logic [DW-1:0] hold_d;

  always_comb hold_d = cap_en ? bus_data_in : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assert_hold_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(hold_q));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          addr_load,
  input  logic [DW-1:0] wdata_in,
  input  logic          wdata_load,
  input  logic          dir_rd,
  input  logic          start,
  input  logic          grant,
  input  logic          ack_n,
  input  logic [DW-1:0] bus_data_in,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data_out,
  output logic          bus_rd,
  output logic          drv_en,
  output logic          adr_stb_n,
  output logic          dat_stb_n,
  output logic          busy,
  output logic [DW-1:0] rd_hold
);
  logic capture;

  bcs_host_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .addr_in    (addr_in),
    .addr_load  (addr_load),
    .wdata_in   (wdata_in),
    .wdata_load (wdata_load),
    .addr_q     (bus_addr),
    .wdata_q    (bus_data_out)
  );

  bcs_timing_chain u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .grant     (grant),
    .dir_rd    (dir_rd),
    .ack_n     (ack_n),
    .drv_en    (drv_en),
    .adr_stb_n (adr_stb_n),
    .dat_stb_n (dat_stb_n),
    .busy      (busy),
    .cyc_rd    (bus_rd),
    .capture   (capture)
  );

  bcs_read_hold #(.DW(DW)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (capture),
    .bus_data_in (bus_data_in),
    .hold_q      (rd_hold)
  );

  assert_write_keeps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_rd) |=> $stable(rd_hold));
endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr_in, wdata_in, bus_data_in;
  logic       addr_load, wdata_load, dir_rd, start, grant, ack_n;
  logic [7:0] bus_addr, bus_data_out, rd_hold;
  logic       bus_rd, drv_en, adr_stb_n, dat_stb_n, busy;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_load(addr_load),
    .wdata_in(wdata_in), .wdata_load(wdata_load), .dir_rd(dir_rd),
    .start(start), .grant(grant), .ack_n(ack_n), .bus_data_in(bus_data_in),
    .bus_addr(bus_addr), .bus_data_out(bus_data_out), .bus_rd(bus_rd),
    .drv_en(drv_en), .adr_stb_n(adr_stb_n), .dat_stb_n(dat_stb_n),
    .busy(busy), .rd_hold(rd_hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Outputs are packed as {drv_en, adr_stb_n, dat_stb_n, busy}
  function automatic logic [3:0] ctl();
    return {drv_en, adr_stb_n, dat_stb_n, busy};
  endfunction

  task automatic do_cycle(input logic [7:0] a, input logic [7:0] wd, input logic rd,
                          input logic [7:0] bd, input int dly, input bit poke, input bit early);
    logic [7:0] prev;
    @(negedge clk);
    addr_in = a; addr_load = 1'b1; wdata_in = wd; wdata_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0; wdata_load = 1'b0;
    check("R7 address load", bus_addr, a);
    check("R8 write data load", bus_data_out, wd);
    prev = rd_hold;
    dir_rd = rd; start = 1'b1; bus_data_in = bd;
    if (early) ack_n = 1'b0;
    @(negedge clk);
    start = 1'b0; dir_rd = ~rd;
    check("R2 drive stage", ctl(), 4'b1111);
    check("R10 direction", bus_rd, rd);
    if (poke) begin
      start = 1'b1; addr_load = 1'b1; addr_in = ~a; wdata_load = 1'b1; wdata_in = ~wd;
    end
    @(negedge clk);
    start = 1'b0; addr_load = 1'b0; wdata_load = 1'b0;
    check("R3 address strobe", ctl(), 4'b1011);
    if (poke) begin
      check("R7 load ignored while busy", bus_addr, a);
      check("R8 load ignored while busy", bus_data_out, wd);
    end
    @(negedge clk);
    check(early ? "R11 early ack ignored" : "R4 data strobe", ctl(), 4'b1001);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check("R5 strobes hold awaiting ack", ctl(), 4'b1001);
    end
    ack_n = 1'b0;
    @(negedge clk);
    ack_n = 1'b1;
    check("R5 strobes release", ctl(), 4'b1111);
    check("R10 direction held", bus_rd, rd);
    check(rd ? "R9 read captured" : "R8 write keeps hold", rd_hold, rd ? bd : prev);
    @(negedge clk);
    check("R5 drivers off", ctl(), 4'b0110);
    check("R9 hold kept", rd_hold, rd ? bd : prev);
  endtask

  initial begin
    rst_n = 1'b0; addr_in = '0; wdata_in = '0; bus_data_in = '0;
    addr_load = 1'b0; wdata_load = 1'b0; dir_rd = 1'b0; start = 1'b0;
    grant = 1'b1; ack_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset controls", ctl(), 4'b0110);
    check("R1 reset hold", rd_hold, 8'h00);
    check("R1 reset addr", bus_addr, 8'h00);
    check("R1 reset wdata", bus_data_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // start without grant must be ignored
    grant = 1'b0; start = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 no grant no cycle", ctl(), 4'b0110);
    start = 1'b0; grant = 1'b1;

    // sweep of values, directions and acknowledge delays
    for (int i = 0; i < 32; i++) begin
      do_cycle(8'(i * 37 + 5), 8'(8'hF0 ^ (i * 11)), i[0], 8'(i * 29 + 3), i % 4, 1'b0, 1'b0);
    end

    // start and loads while busy
    do_cycle(8'h5A, 8'hC3, 1'b1, 8'h99, 1, 1'b1, 1'b0);
    do_cycle(8'hA5, 8'h3C, 1'b0, 8'h11, 2, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 start in busy did not restart", ctl(), 4'b0110);

    // acknowledge held low from the start
    do_cycle(8'h21, 8'h42, 1'b1, 8'h84, 0, 1'b0, 1'b1);
    do_cycle(8'h12, 8'h24, 1'b0, 8'h77, 0, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule